// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data between one narrow port and a wide side made of two halves, a low half and a high half. Each of the three ports has the same width. In the narrow-to-wide direction, two successive narrow words are collected and shown together on the two wide halves as one double-width word. In the other direction, either stored wide half can be returned to the narrow port. Each bidirectional pin group is modelled as an input vector, an output vector and an output-enable vector.

All storage loads on the rising edge of one clock. Each of the four capture paths has its own active-low load strobe. The narrow-to-low path is two registers deep and the narrow-to-high path is one register deep. To build a wide word, clock the first word with only the low-path strobe active. Then clock the second word with both narrow-side strobes active. After that edge, the first word is on the low half and the second word is on the high half. The half-select and both drive requests are registered, so mux and direction changes take effect on a clock edge. A synchronous active-high reset clears all data, selects the high half and turns both sides off.

Top module: `bus_xchg_n2w`

## Requirements
- R1: While `rst` is high at a rising edge, all data registers are cleared to zero, the select register is set to the high half, and both sides are turned off. After that edge, every data output and every output-enable bit reads 0.
- R2: When `cap_n2hi_n` is low at an edge, the word on `nar_in` appears on `whi_out` right after that edge.
- R3: The narrow-to-low path has two stages that both advance on an edge where `cap_n2lo_n` is low. A narrow word reaches `wlo_out` after the second such edge. After the first such edge, `wlo_out` shows the word that was waiting in the first stage.
- R4: Clock word X with only `cap_n2lo_n` low, then word Y with both `cap_n2lo_n` and `cap_n2hi_n` low. The concatenation {`whi_out`, `wlo_out`} then equals {Y, X}.
- R5: The low-return register loads `wlo_in` only on edges where `cap_lo2n_n` is low. The high-return register loads `whi_in` only on edges where `cap_hi2n_n` is low. Neither strobe affects the other register.
- R6: `take_lo` is sampled at each edge. If it was sampled 1, `nar_out` shows the stored low-return word. If it was sampled 0, `nar_out` shows the stored high-return word. A change of `take_lo` between edges has no effect until the next edge.
- R7: `nar_drive_n` and `wide_drive_n` are active low and registered. A side drives from the edge after its request is sampled low. Its output-enable vector is then all ones. While the registered request is high, the vector is all zeros. The two sides are independent, so both or neither may drive.
- R8: A data output whose path strobes are all high at an edge keeps its value across that edge.
- R9: Data outputs change only at clock edges. A change on any data, strobe or select input between edges leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| nar_in | input | WORD_W | Narrow port input data |
| nar_out | output | WORD_W | Narrow port output data |
| nar_oe | output | WORD_W | Narrow port drive enable, one bit per pin |
| wlo_in | input | WORD_W | Wide low-half input data |
| wlo_out | output | WORD_W | Wide low-half output data |
| wlo_oe | output | WORD_W | Wide low-half drive enable |
| whi_in | input | WORD_W | Wide high-half input data |
| whi_out | output | WORD_W | Wide high-half output data |
| whi_oe | output | WORD_W | Wide high-half drive enable |
| cap_n2lo_n | input | 1 | Load strobe, narrow-to-low path, active low |
| cap_n2hi_n | input | 1 | Load strobe, narrow-to-high path, active low |
| cap_lo2n_n | input | 1 | Load strobe, low-return register, active low |
| cap_hi2n_n | input | 1 | Load strobe, high-return register, active low |
| take_lo | input | 1 | Half-select: 1 returns low half, 0 returns high half |
| nar_drive_n | input | 1 | Narrow side drive request, active low |
| wide_drive_n | input | 1 | Wide side drive request, active low |

## Verification
The bench builds the block with `WORD_W` = 4, so that every value a word can take is small enough to enumerate. With four-bit words, every ordered pair of narrow words is packed into a wide word. Every pair of wide halves is returned through both select settings. That covers each bit position in both polarities on all four paths and on the select mux. The one-stage lag of the low path is checked against the word from the previous pair in every iteration.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

  localparam int LO_PATH_STAGES = 2;
  localparam int HI_PATH_STAGES = 1;
  localparam int RET_STAGES     = 1;

  typedef struct packed {
    logic sel_lo;
    logic nar_off;
    logic wide_off;
  } xchg_ctl_t;

  localparam xchg_ctl_t CTL_RESET = '{sel_lo: 1'b0, nar_off: 1'b1, wide_off: 1'b1};

  function automatic logic strobe_hit(input logic strobe_n);
    return ~strobe_n;
  endfunction

endpackage

// File: rtl/xchg_pipe.sv
module xchg_pipe #(
  parameter int W      = 12,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else if (load) begin
      for (int i = LAST; i > 0; i--) begin
        chain_q[i] <= chain_q[i-1];
      end
      chain_q[0] <= d;
    end
  end

  assign q = chain_q[LAST];
endmodule

// File: rtl/xchg_ctl_reg.sv
module xchg_ctl_reg
  import xchg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      take_lo,
  input  logic      nar_drive_n,
  input  logic      wide_drive_n,
  output xchg_ctl_t ctl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_RESET;
    end else begin
      ctl_q.sel_lo   <= take_lo;
      ctl_q.nar_off  <= nar_drive_n;
      ctl_q.wide_off <= wide_drive_n;
    end
  end
endmodule

// File: rtl/xchg_return_mux.sv
module xchg_return_mux #(
  parameter int W = 12
) (
  input  logic         sel_lo,
  input  logic [W-1:0] lo_word,
  input  logic [W-1:0] hi_word,
  output logic [W-1:0] y
);
  function automatic logic [W-1:0] pick_half(input logic s,
                                             input logic [W-1:0] a,
                                             input logic [W-1:0] b);
    return s ? a : b;
  endfunction

  assign y = pick_half(sel_lo, lo_word, hi_word);
endmodule

// File: rtl/bus_xchg_n2w.sv
module bus_xchg_n2w
  import xchg_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] nar_in,
  output logic [WORD_W-1:0] nar_out,
  output logic [WORD_W-1:0] nar_oe,
  input  logic [WORD_W-1:0] wlo_in,
  output logic [WORD_W-1:0] wlo_out,
  output logic [WORD_W-1:0] wlo_oe,
  input  logic [WORD_W-1:0] whi_in,
  output logic [WORD_W-1:0] whi_out,
  output logic [WORD_W-1:0] whi_oe,
  input  logic              cap_n2lo_n,
  input  logic              cap_n2hi_n,
  input  logic              cap_lo2n_n,
  input  logic              cap_hi2n_n,
  input  logic              take_lo,
  input  logic              nar_drive_n,
  input  logic              wide_drive_n
);
  // named load events, visible to the bound checker
  logic n2lo_fire, n2hi_fire, lo2n_fire, hi2n_fire;
  assign n2lo_fire = strobe_hit(cap_n2lo_n);
  assign n2hi_fire = strobe_hit(cap_n2hi_n);
  assign lo2n_fire = strobe_hit(cap_lo2n_n);
  assign hi2n_fire = strobe_hit(cap_hi2n_n);

  xchg_ctl_t ctl_q;
  logic [WORD_W-1:0] ret_lo_q, ret_hi_q;

  // narrow to low half: two stages (R3)
  xchg_pipe #(.W(WORD_W), .STAGES(LO_PATH_STAGES)) u_n2lo (
    .clk(clk), .rst(rst), .load(n2lo_fire), .d(nar_in), .q(wlo_out)
  );

  // narrow to high half: one stage (R2)
  xchg_pipe #(.W(WORD_W), .STAGES(HI_PATH_STAGES)) u_n2hi (
    .clk(clk), .rst(rst), .load(n2hi_fire), .d(nar_in), .q(whi_out)
  );

  // wide halves back toward narrow (R5)
  xchg_pipe #(.W(WORD_W), .STAGES(RET_STAGES)) u_lo2n (
    .clk(clk), .rst(rst), .load(lo2n_fire), .d(wlo_in), .q(ret_lo_q)
  );

  xchg_pipe #(.W(WORD_W), .STAGES(RET_STAGES)) u_hi2n (
    .clk(clk), .rst(rst), .load(hi2n_fire), .d(whi_in), .q(ret_hi_q)
  );

  xchg_ctl_reg u_ctl (
    .clk(clk), .rst(rst), .take_lo(take_lo),
    .nar_drive_n(nar_drive_n), .wide_drive_n(wide_drive_n), .ctl_q(ctl_q)
  );

  xchg_return_mux #(.W(WORD_W)) u_mux (
    .sel_lo(ctl_q.sel_lo), .lo_word(ret_lo_q), .hi_word(ret_hi_q), .y(nar_out)
  );

  assign nar_oe = {WORD_W{~ctl_q.nar_off}};
  assign wlo_oe = {WORD_W{~ctl_q.wide_off}};
  assign whi_oe = {WORD_W{~ctl_q.wide_off}};
endmodule

// File: rtl/xchg_checker.sv
module xchg_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         n2lo_fire,
  input logic         n2hi_fire,
  input logic         lo2n_fire,
  input logic         hi2n_fire,
  input logic         take_lo,
  input logic         nar_drive_n,
  input logic         wide_drive_n,
  input logic [W-1:0] nar_in,
  input logic [W-1:0] wlo_in,
  input logic [W-1:0] whi_in,
  input logic [W-1:0] nar_out,
  input logic [W-1:0] nar_oe,
  input logic [W-1:0] wlo_out,
  input logic [W-1:0] wlo_oe,
  input logic [W-1:0] whi_out,
  input logic [W-1:0] whi_oe
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (nar_out == '0 && wlo_out == '0 && whi_out == '0 &&
             nar_oe == '0 && wlo_oe == '0 && whi_oe == '0));

  p_hi_one_stage_r2: assert property (@(posedge clk) disable iff (rst)
    n2hi_fire |=> whi_out == $past(nar_in));

  p_lo_two_stage_r3: assert property (@(posedge clk) disable iff (rst)
    (n2lo_fire && $past(n2lo_fire) && !$past(rst)) |=> wlo_out == $past(nar_in, 2));

  p_pick_lo_r6: assert property (@(posedge clk) disable iff (rst)
    (take_lo && lo2n_fire) |=> nar_out == $past(wlo_in));

  p_pick_hi_r6: assert property (@(posedge clk) disable iff (rst)
    (!take_lo && hi2n_fire) |=> nar_out == $past(whi_in));

  p_nar_off_r7: assert property (@(posedge clk) disable iff (rst)
    nar_drive_n |=> nar_oe == '0);

  p_nar_on_r7: assert property (@(posedge clk) disable iff (rst)
    !nar_drive_n |=> nar_oe == '1);

  p_wide_off_r7: assert property (@(posedge clk) disable iff (rst)
    wide_drive_n |=> (wlo_oe == '0 && whi_oe == '0));

  p_wide_on_r7: assert property (@(posedge clk) disable iff (rst)
    !wide_drive_n |=> (wlo_oe == '1 && whi_oe == '1));

  p_hold_hi_r8: assert property (@(posedge clk) disable iff (rst)
    !n2hi_fire |=> $stable(whi_out));

  p_hold_lo_r8: assert property (@(posedge clk) disable iff (rst)
    !n2lo_fire |=> $stable(wlo_out));
endmodule

bind bus_xchg_n2w xchg_checker #(.W(WORD_W)) u_xchg_checker (
  .clk(clk), .rst(rst),
  .n2lo_fire(n2lo_fire), .n2hi_fire(n2hi_fire),
  .lo2n_fire(lo2n_fire), .hi2n_fire(hi2n_fire),
  .take_lo(take_lo), .nar_drive_n(nar_drive_n), .wide_drive_n(wide_drive_n),
  .nar_in(nar_in), .wlo_in(wlo_in), .whi_in(whi_in),
  .nar_out(nar_out), .nar_oe(nar_oe),
  .wlo_out(wlo_out), .wlo_oe(wlo_oe),
  .whi_out(whi_out), .whi_oe(whi_oe)
);

// File: tb/test_bus_xchg_n2w.sv
module test_bus_xchg_n2w;
  localparam int BW = 4;
  localparam int NV = 1 << BW;
  localparam logic [BW-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst;
  logic [BW-1:0] nar_in, wlo_in, whi_in;
  logic [BW-1:0] nar_out, nar_oe, wlo_out, wlo_oe, whi_out, whi_oe;
  logic cap_n2lo_n, cap_n2hi_n, cap_lo2n_n, cap_hi2n_n;
  logic take_lo, nar_drive_n, wide_drive_n;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bus_xchg_n2w #(.WORD_W(BW)) i_bus_xchg_n2w (
    .clk(clk), .rst(rst),
    .nar_in(nar_in), .nar_out(nar_out), .nar_oe(nar_oe),
    .wlo_in(wlo_in), .wlo_out(wlo_out), .wlo_oe(wlo_oe),
    .whi_in(whi_in), .whi_out(whi_out), .whi_oe(whi_oe),
    .cap_n2lo_n(cap_n2lo_n), .cap_n2hi_n(cap_n2hi_n),
    .cap_lo2n_n(cap_lo2n_n), .cap_hi2n_n(cap_hi2n_n),
    .take_lo(take_lo), .nar_drive_n(nar_drive_n), .wide_drive_n(wide_drive_n)
  );

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_strobes();
    cap_n2lo_n = 1'b1; cap_n2hi_n = 1'b1; cap_lo2n_n = 1'b1; cap_hi2n_n = 1'b1;
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " nar_out"}, nar_out, 0);
    chk({tag, " wlo_out"}, wlo_out, 0);
    chk({tag, " whi_out"}, whi_out, 0);
    chk({tag, " nar_oe"}, nar_oe, 0);
    chk({tag, " wlo_oe"}, wlo_oe, 0);
    chk({tag, " whi_oe"}, whi_oe, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [BW-1:0] prev_b;
    logic [BW-1:0] s_nar, s_lo, s_hi;

    // R1: reset wins over active strobes and drive requests
    rst = 1'b1;
    nar_in = 4'h5; wlo_in = 4'h6; whi_in = 4'h7;
    cap_n2lo_n = 1'b0; cap_n2hi_n = 1'b0; cap_lo2n_n = 1'b0; cap_hi2n_n = 1'b0;
    take_lo = 1'b1; nar_drive_n = 1'b0; wide_drive_n = 1'b0;
    tick();
    tick();
    check_reset_state("R1 reset");
    rst = 1'b0;
    idle_strobes();
    nar_drive_n = 1'b1; wide_drive_n = 1'b1;
    tick();

    // R7: registered, independent drive enables
    nar_drive_n = 1'b0;
    #1 chk("R7 nar_oe before edge", nar_oe, 0);
    tick();
    chk("R7 nar on", nar_oe, ONES);
    chk("R7 wlo off", wlo_oe, 0);
    chk("R7 whi off", whi_oe, 0);
    wide_drive_n = 1'b0;
    tick();
    chk("R7 both on nar", nar_oe, ONES);
    chk("R7 both on wlo", wlo_oe, ONES);
    chk("R7 both on whi", whi_oe, ONES);
    nar_drive_n = 1'b1;
    tick();
    chk("R7 nar off", nar_oe, 0);
    chk("R7 wide stays on", wlo_oe, ONES);
    nar_drive_n = 1'b0;
    tick();

    // R3, R4, R8: every ordered pair of narrow words
    prev_b = '0;
    for (int a = 0; a < NV; a++) begin
      for (int b = 0; b < NV; b++) begin
        nar_in = BW'(a); cap_n2lo_n = 1'b0; cap_n2hi_n = 1'b1;
        tick();
        chk("R3 low lags one word", wlo_out, prev_b);
        chk("R8 high held", whi_out, prev_b);
        nar_in = BW'(b); cap_n2hi_n = 1'b0;
        tick();
        idle_strobes();
        chk("R4 wide word", {whi_out, wlo_out}, {BW'(b), BW'(a)});
        prev_b = BW'(b);
      end
    end

    // R2: single high stage, low half held (R8)
    nar_in = 4'h9; cap_n2hi_n = 1'b0;
    tick();
    idle_strobes();
    chk("R2 high one edge", whi_out, 4'h9);
    chk("R8 low held", wlo_out, 4'hF);

    // R3: explicit two-edge walk
    nar_in = 4'h6; cap_n2lo_n = 1'b0;
    tick();
    chk("R3 first edge", wlo_out, 4'hF);
    nar_in = 4'h3;
    tick();
    idle_strobes();
    chk("R3 second edge", wlo_out, 4'h6);
    chk("R8 high held again", whi_out, 4'h9);

    // R6: every pair of wide halves through both selects
    for (int p = 0; p < NV; p++) begin
      for (int q = 0; q < NV; q++) begin
        wlo_in = BW'(p); whi_in = BW'(q);
        cap_lo2n_n = 1'b0; cap_hi2n_n = 1'b0; take_lo = 1'b1;
        tick();
        chk("R6 select low half", nar_out, p);
        idle_strobes();
        wlo_in = ~BW'(p); whi_in = ~BW'(p); take_lo = 1'b0;
        #1 chk("R6 select waits for edge", nar_out, p);
        tick();
        chk("R6 select high half", nar_out, q);
      end
    end

    // R5: return registers load independently
    wlo_in = 4'hA; whi_in = 4'hB; cap_lo2n_n = 1'b0; cap_hi2n_n = 1'b0; take_lo = 1'b1;
    tick();
    idle_strobes();
    whi_in = 4'hC; cap_hi2n_n = 1'b0; wlo_in = 4'h1;
    tick();
    idle_strobes();
    chk("R5 low kept when only high loads", nar_out, 4'hA);
    take_lo = 1'b0;
    tick();
    chk("R5 high loaded", nar_out, 4'hC);
    wlo_in = 4'hD; whi_in = 4'h2; cap_lo2n_n = 1'b0;
    tick();
    idle_strobes();
    chk("R5 high kept when only low loads", nar_out, 4'hC);
    take_lo = 1'b1;
    tick();
    chk("R5 low loaded", nar_out, 4'hD);

    // R9: mid-cycle input changes do not reach outputs
    s_nar = nar_out; s_lo = wlo_out; s_hi = whi_out;
    nar_in = ~nar_in; wlo_in = 4'h0; whi_in = 4'hF; take_lo = 1'b0;
    cap_n2lo_n = 1'b0; cap_n2hi_n = 1'b0; cap_lo2n_n = 1'b0; cap_hi2n_n = 1'b0;
    nar_drive_n = 1'b1; wide_drive_n = 1'b1;
    #2;
    chk("R9 nar_out steady", nar_out, s_nar);
    chk("R9 wlo_out steady", wlo_out, s_lo);
    chk("R9 whi_out steady", whi_out, s_hi);
    chk("R9 nar_oe steady", nar_oe, ONES);
    idle_strobes();
    take_lo = 1'b1; nar_drive_n = 1'b0; wide_drive_n = 1'b0;

    // R8: several idle edges with changing data
    for (int k = 0; k < 3; k++) begin
      nar_in = BW'(k * 5 + 1); wlo_in = BW'(k + 7); whi_in = BW'(k * 3);
      tick();
      chk("R8 idle nar_out", nar_out, s_nar);
      chk("R8 idle wlo_out", wlo_out, s_lo);
      chk("R8 idle whi_out", whi_out, s_hi);
    end

    // R1: reset in the middle of operation
    rst = 1'b1;
    tick();
    check_reset_state("R1 mid-run reset");
    rst = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule